// File: doc/BRIEF.md
# Coin Change Selector for a Quarter

This block decides how to pay back a fixed 25 cents using two coin stocks: 10-cent pieces and 5-cent pieces. It reads the number of each coin currently held, as two 4-bit counts. It returns the number of 10-cent pieces and the number of 5-cent pieces to eject. If the stock cannot make the amount, it raises a flag instead.

The block has no clock and no state. The counts come from counters elsewhere in the machine. The ejection hardware reads the outputs and then decrements those counters.

The block tries a fixed list of coin mixes that each total 25 cents, starting with the mix that uses the most 10-cent pieces. It picks the first mix that the stock can cover. This keeps the 5-cent stock, which is the only one able to complete odd multiples of five, as full as possible.

Top module: `coin_change_top`

## Requirements
- R1: Whenever the no-change flag is low, (10 × dime output) + (5 × nickel output) equals 25.
- R2: The dime output never exceeds the dime count, and the nickel output never exceeds the nickel count.
- R3: With at least 2 dimes and at least 1 nickel in stock, the outputs are 2 dimes and 1 nickel. This holds even if 5 or more nickels are also available.
- R4: If R3 does not apply, and the stock holds at least 1 dime and at least 3 nickels, the outputs are 1 dime and 3 nickels.
- R5: If neither R3 nor R4 applies, and the stock holds at least 5 nickels, the outputs are 0 dimes and 5 nickels.
- R6: If none of R3 to R5 applies, the no-change flag is 1 and both coin outputs are 0. Otherwise the flag is 0.
- R7: Counts at the top of the 4-bit range (up to 15) are taken at full value, so 15 dimes with 15 nickels yields 2 dimes and 1 nickel.
- R8: Stocks just short of the amount are refused with the flag. Examples are 0 dimes with 4 nickels, 1 dime with 2 nickels, and 2 or more dimes with 0 nickels.
- R9: The dime output is 2 bits wide and the nickel output is 3 bits wide, read as unsigned counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dime_count | input | 4 | Unsigned number of 10-cent pieces in stock |
| nickel_count | input | 4 | Unsigned number of 5-cent pieces in stock |
| give_dimes | output | 2 | Number of 10-cent pieces to eject |
| give_nickels | output | 3 | Number of 5-cent pieces to eject |
| no_change | output | 1 | 1 when no mix worth 25 cents fits the stock |

## Verification
The in-line checks assume both counts are fully known values, with no X or Z bits. They also assume each combinational evaluation finishes before its inputs change again.

The bench therefore drives only defined 4-bit values and holds each pair for half a clock period before it samples the outputs. All 256 count pairs are swept. Random pairs from a fixed seed are then added, together with the directed near-empty and full-stock cases from R7 and R8.

// File: rtl/coin_change_pkg.sv
// Package: coin values and the candidate mix table.
// The table is derived by arithmetic, never written out.
// Candidate index 0 holds the most 10-cent pieces. Each later index holds one fewer.
package coin_change_pkg;

    localparam int unsigned DIME_VALUE   = 10;
    localparam int unsigned NICKEL_VALUE = 5;
    localparam int unsigned CHANGE_VALUE = 25;

    // Number of large coins used by candidate idx
    function automatic int unsigned cand_dimes(input int unsigned idx,
                                               input int unsigned max_d);
        return max_d - idx;
    endfunction

    // Cents left for small coins after the large coins of candidate idx
    function automatic int unsigned cand_rest(input int unsigned idx,
                                              input int unsigned max_d,
                                              input int unsigned change,
                                              input int unsigned dval);
        return change - cand_dimes(idx, max_d) * dval;
    endfunction

    // Number of small coins used by candidate idx
    function automatic int unsigned cand_nickels(input int unsigned idx,
                                                 input int unsigned max_d,
                                                 input int unsigned change,
                                                 input int unsigned dval,
                                                 input int unsigned nval);
        return cand_rest(idx, max_d, change, dval) / nval;
    endfunction

    // 1 when the small coins pay the remainder exactly
    function automatic bit cand_exact(input int unsigned idx,
                                      input int unsigned max_d,
                                      input int unsigned change,
                                      input int unsigned dval,
                                      input int unsigned nval);
        return (cand_rest(idx, max_d, change, dval) % nval) == 0;
    endfunction

endpackage

// File: rtl/coin_cand_check.sv
// Tests one candidate mix against the stock.
// Assumes the mix constants are already reduced: a mix that cannot pay exactly has EXACT = 0.
// The candidate is feasible when it pays exactly and both counts cover its needs.
module coin_cand_check #(
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned NEED_D = 2,
    parameter int unsigned NEED_N = 1,
    parameter bit          EXACT  = 1'b1
) (
    input  logic [CNT_W-1:0] dime_count,
    input  logic [CNT_W-1:0] nickel_count,
    output logic             feasible
);

    // Compare both counts with what this mix consumes
    always_comb begin
        feasible = EXACT
                && (int'({1'b0, dime_count})   >= int'(NEED_D))
                && (int'({1'b0, nickel_count}) >= int'(NEED_N));
    end

endmodule

// File: rtl/coin_prio_pick.sv
// Fixed-priority picker: grants the lowest-index feasible candidate.
// Assumes index 0 is the preferred mix, the one with the most large coins.
module coin_prio_pick #(
    parameter int unsigned NUM = 3
) (
    input  logic [NUM-1:0] feasible,
    output logic [NUM-1:0] grant,
    output logic           none
);

    // Walk from the highest priority downward and keep the first hit
    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < int'(NUM); i++) begin
            if (feasible[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
        none = !taken;

        assert_grant_onehot_R6: assert ($onehot0(grant))
            else $error("grant not one-hot");
        assert_grant_feasible_R2: assert ((grant & ~feasible) == '0)
            else $error("grant on infeasible candidate");
        assert_flag_consistent_R6: assert (none == (feasible == '0))
            else $error("none flag disagrees with feasibility");
        for (int i = 0; i < int'(NUM); i++) begin
            for (int j = 0; j < i; j++) begin
                assert_priority_R4: assert (!(grant[i] && feasible[j]))
                    else $error("lower-priority mix chosen over feasible one");
            end
        end
    end

endmodule

// File: rtl/coin_out_mux.sv
// Turns the one-hot grant into coin counts.
// Assumes grant is one-hot or all zero.
// With an all-zero grant both counts are driven to zero.
module coin_out_mux
    import coin_change_pkg::*;
#(
    parameter int unsigned NUM    = 3,
    parameter int unsigned D_W    = 2,
    parameter int unsigned N_W    = 3,
    parameter int unsigned MAX_D  = 2,
    parameter int unsigned CHANGE = 25,
    parameter int unsigned DVAL   = 10,
    parameter int unsigned NVAL   = 5
) (
    input  logic [NUM-1:0] grant,
    output logic [D_W-1:0] give_dimes,
    output logic [N_W-1:0] give_nickels
);

    // OR together the coin counts of the granted candidate
    always_comb begin
        give_dimes   = '0;
        give_nickels = '0;
        for (int i = 0; i < int'(NUM); i++) begin
            if (grant[i]) begin
                give_dimes   = give_dimes
                             | D_W'(cand_dimes(i, MAX_D));
                give_nickels = give_nickels
                             | N_W'(cand_nickels(i, MAX_D, CHANGE, DVAL, NVAL));
            end
        end

        if (grant != '0) begin
            assert_sum_exact_R1: assert (int'({1'b0, give_dimes}) * int'(DVAL)
                                       + int'({1'b0, give_nickels}) * int'(NVAL)
                                       == int'(CHANGE))
                else $error("dispensed value not exact");
        end else begin
            assert_idle_zero_R6: assert (give_dimes == '0 && give_nickels == '0)
                else $error("coins given while refusing");
        end
    end

endmodule

// File: rtl/coin_change_top.sv
// Top level: chooses a mix of large and small coins worth CHANGE.
// Prefers the mix with the most large coins.
// Purely combinational. Assumes the counts are stable, known unsigned values.
module coin_change_top
    import coin_change_pkg::*;
#(
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned CHANGE = CHANGE_VALUE,
    parameter int unsigned DVAL   = DIME_VALUE,
    parameter int unsigned NVAL   = NICKEL_VALUE
) (
    input  logic [CNT_W-1:0]                          dime_count,
    input  logic [CNT_W-1:0]                          nickel_count,
    output logic [$clog2(CHANGE/DIME_VALUE+1)-1:0]   give_dimes,
    output logic [$clog2(CHANGE/NICKEL_VALUE+1)-1:0] give_nickels,
    output logic                                      no_change
);

    localparam int unsigned MAX_D = CHANGE / DVAL;
    localparam int unsigned MAX_N = CHANGE / NVAL;
    localparam int unsigned NUM   = MAX_D + 1;
    localparam int unsigned D_W   = $clog2(CHANGE / DIME_VALUE + 1);
    localparam int unsigned N_W   = $clog2(CHANGE / NICKEL_VALUE + 1);

    logic [NUM-1:0] feasible;
    logic [NUM-1:0] grant;
    logic           none;

    // One feasibility test per candidate mix
    for (genvar g = 0; g < int'(NUM); g++) begin : g_cand
        coin_cand_check #(
            .CNT_W  (CNT_W),
            .NEED_D (cand_dimes(g, MAX_D)),
            .NEED_N (cand_nickels(g, MAX_D, CHANGE, DVAL, NVAL)),
            .EXACT  (cand_exact(g, MAX_D, CHANGE, DVAL, NVAL))
        ) u_check (
            .dime_count   (dime_count),
            .nickel_count (nickel_count),
            .feasible     (feasible[g])
        );
    end

    coin_prio_pick #(
        .NUM (NUM)
    ) u_pick (
        .feasible (feasible),
        .grant    (grant),
        .none     (none)
    );

    coin_out_mux #(
        .NUM    (NUM),
        .D_W    (D_W),
        .N_W    (N_W),
        .MAX_D  (MAX_D),
        .CHANGE (CHANGE),
        .DVAL   (DVAL),
        .NVAL   (NVAL)
    ) u_mux (
        .grant        (grant),
        .give_dimes   (give_dimes),
        .give_nickels (give_nickels)
    );

    // Drive the refusal flag from the picker
    always_comb begin
        no_change = none;
    end

    // Keeps MAX_N visibly in range of the small-coin output width
    initial begin
        assert_width_fits_R9: assert (MAX_N < (1 << N_W))
            else $error("small-coin output too narrow");
    end

endmodule

// File: tb/coin_change_top_bench.sv
// Bench: full sweep of all count pairs, then seeded random pairs and directed corners.
// Expected results come from a model of the priority list written from the requirements.
module coin_change_top_bench;

    logic       clk = 1'b0;
    logic [3:0] dime_count;
    logic [3:0] nickel_count;
    logic [1:0] give_dimes;
    logic [2:0] give_nickels;
    logic       no_change;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    coin_change_top u_coin_change_top (
        .dime_count   (dime_count),
        .nickel_count (nickel_count),
        .give_dimes   (give_dimes),
        .give_nickels (give_nickels),
        .no_change    (no_change)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s d=%0d n=%0d actual=%0d expected=%0d",
                     req, dime_count, nickel_count, act, exp);
        end
    endtask

    // Reference: first mix of the list that the stock covers
    function automatic void model(input int d, input int n,
                                  output int ed, output int en, output bit enc);
        enc = 1'b0;
        if (d >= 2 && n >= 1) begin
            ed = 2; en = 1;
        end else if (d >= 1 && n >= 3) begin
            ed = 1; en = 3;
        end else if (n >= 5) begin
            ed = 0; en = 5;
        end else begin
            ed = 0; en = 0; enc = 1'b1;
        end
    endfunction

    task automatic apply(input int d, input int n, input string tag);
        int ed, en;
        bit enc;
        string rule;
        @(posedge clk);
        dime_count   = 4'(d);
        nickel_count = 4'(n);
        @(negedge clk);
        model(d, n, ed, en, enc);
        rule = enc ? "R6" : (ed == 2 ? "R3" : (ed == 1 ? "R4" : "R5"));
        if (tag != "") rule = tag;

        check(no_change == enc, {rule, " flag"}, int'(no_change), int'(enc));
        check(int'(give_dimes) == ed, {rule, " dimes"}, int'(give_dimes), ed);
        check(int'(give_nickels) == en, {rule, " nickels"}, int'(give_nickels), en);
        if (!no_change) begin
            check(int'(give_dimes) * 10 + int'(give_nickels) * 5 == 25, "R1 sum",
                  int'(give_dimes) * 10 + int'(give_nickels) * 5, 25);
        end
        check(int'(give_dimes) <= d && int'(give_nickels) <= n, "R2 stock",
              int'(give_dimes) * 100 + int'(give_nickels), d * 100 + n);
    endtask

    initial begin
        dime_count   = '0;
        nickel_count = '0;

        // Empty stock is the starting state: refusal with zero outputs (R6)
        apply(0, 0, "R6");

        // Full sweep of all 256 pairs (R1 to R6, R9 output widths)
        for (int d = 0; d < 16; d++) begin
            for (int n = 0; n < 16; n++) begin
                apply(d, n, "");
            end
        end

        // Directed corners
        apply(15, 15, "R7");
        apply(15, 0, "R8");
        apply(0, 4, "R8");
        apply(1, 2, "R8");
        apply(2, 0, "R8");
        apply(0, 15, "R7");
        apply(1, 15, "R4");
        apply(2, 5, "R3");

        // Seeded random pairs
        void'($urandom(32'd2017));
        for (int k = 0; k < 300; k++) begin
            apply(int'($urandom_range(15, 0)), int'($urandom_range(15, 0)), "");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule